// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits beside the command sequencer of a single-rank SDRAM controller. On every clock it reports which command may legally go out. The sequencer presents a proposed command and bank. The guard answers with one flag per command code, each valid in that same cycle. When the sequencer actually drives a command onto the memory, it raises an issue strobe for that cycle. The guard then restarts the timing windows that the command opens.

All minimum delays are parameters in picoseconds, next to the clock period. At elaboration they become whole cycle counts. Each bank has a two-state machine: BANK_IDLE moves to BANK_OPEN on an issued ACTIVE, and BANK_OPEN returns to BANK_IDLE on an issued PRECHARGE. The device-wide machine has two states: DEV_RUN moves to DEV_REFRESH on an issued AUTO REFRESH, and DEV_REFRESH returns to DEV_RUN once the refresh cycle time has run out. Every bank and the device keep down-counters that reload on the matching command and stop at zero.

Beyond the usual activate and precharge windows, the guard applies the write-recovery gaps measured from the last data-in beat. It also flags any bank whose row has stayed open longer than the allowed maximum.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Each window in cycles is the picosecond parameter divided by the clock period and rounded up to the next integer, with a minimum of 1. A window of N cycles means that a command issued in cycle t enables the dependent command from cycle t+N.
- R2: ACTIVE to a bank is allowed only when all of these hold: the bank is idle, the precharge window since its last PRECHARGE has passed, the row cycle window since its last ACTIVE has passed, the activate-to-activate window since any ACTIVE has passed, and the refresh cycle window since the last AUTO REFRESH has passed.
- R3: READ and WRITE to a bank are allowed only when the bank is open and the activate-to-column window since its ACTIVE has passed. An idle bank never allows them.
- R4: PRECHARGE to an open bank needs the minimum row-active window since its ACTIVE. It also needs BURST_LEN-1+2 cycles after a WRITE to that bank. PRECHARGE to an idle bank is always allowed and leaves every timing window unchanged.
- R5: READ after a WRITE is allowed from BURST_LEN-1+1 cycles after the WRITE. WRITE after WRITE and READ after READ are allowed on consecutive cycles.
- R6: BURST STOP is allowed from BURST_LEN-1+1 cycles after the last WRITE.
- R7: WRITE after a READ is allowed from CL+BURST_LEN cycles after the READ, where CL is 3 when cas_lat_3 is 1 and 2 when it is 0.
- R8: AUTO REFRESH is allowed only when every bank is idle with its precharge window elapsed and the refresh cycle window since the previous AUTO REFRESH has passed.
- R9: must_pre for a bank rises exactly the maximum row-active window (in cycles) after its ACTIVE and stays high until a PRECHARGE to that bank is issued. In the following cycle it is low.
- R10: Command codes on req_cmd and bits of cmd_ok are: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 BURST STOP, 6 AUTO REFRESH, 7 reserved. NOP is always allowed and the reserved code never is.
- R11: After reset all banks are idle and all windows are clear. ACTIVE and AUTO REFRESH are allowed, and must_pre is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_cmd | input | 3 | Proposed command code |
| req_bank | input | BANK_W | Proposed bank |
| req_issue | input | 1 | The proposed command is issued this cycle |
| cas_lat_3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| cmd_ok | output | 8 | Allowed flag per command code for req_bank |
| must_pre | output | NUM_BANKS | Bank has exceeded its maximum row-active time |

## Verification
The checks assume that the sequencer raises req_issue only for a command whose cmd_ok bit is high in that cycle. They also assume that it never issues the reserved code and only names banks that exist. Under these assumptions the bank and device state machines cannot be driven into an illegal transition. The bench keeps to these limits: it issues a command only on a cycle where its expected value is allowed. While it measures a window, it presents the command only as a probe with the strobe low.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_BST = 3'd5,
        CMD_REF = 3'd6,
        CMD_RSV = 3'd7
    } scg_cmd_e;

    typedef enum logic {
        BANK_IDLE,
        BANK_OPEN
    } bank_state_e;

    typedef enum logic {
        DEV_RUN,
        DEV_REFRESH
    } dev_state_e;

    // Round a picosecond minimum up to whole clocks, never below one.
    function automatic int ps_to_cyc(input int t_ps, input int tck_ps);
        int c;
        c = (t_ps + tck_ps - 1) / tck_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/scg_down_ctr.sv
module scg_down_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign is_zero = (cnt == '0);

endmodule

// File: rtl/scg_bank_track.sv
module scg_bank_track
    import scg_pkg::*;
#(
    parameter int CW       = 5,
    parameter int MW       = 16,
    parameter int RCD_C    = 4,
    parameter int RP_C     = 4,
    parameter int RAS_C    = 9,
    parameter int RC_C     = 12,
    parameter int WRPRE_C  = 3,
    parameter int RASMAX_C = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [2:0] cmd,
    output logic       act_ready,
    output logic       col_ready,
    output logic       pre_ready,
    output logic       settled_idle,
    output logic       must_pre
);

    localparam logic [CW-1:0] RCD_LD   = CW'(RCD_C - 1);
    localparam logic [CW-1:0] RP_LD    = CW'(RP_C - 1);
    localparam logic [CW-1:0] RAS_LD   = CW'(RAS_C - 1);
    localparam logic [CW-1:0] RC_LD    = CW'(RC_C - 1);
    localparam logic [CW-1:0] WRPRE_LD = CW'(WRPRE_C - 1);
    localparam logic [MW-1:0] RMAX_LD  = MW'(RASMAX_C - 1);

    bank_state_e state, state_nx;

    logic do_act, do_pre, do_wr;
    logic rcd_z, rp_z, ras_z, rc_z, wrpre_z, rmax_z;

    assign do_act = hit && (cmd == CMD_ACT);
    assign do_pre = hit && (cmd == CMD_PRE) && (state == BANK_OPEN);
    assign do_wr  = hit && (cmd == CMD_WR);

    scg_down_ctr #(.W(CW)) u_rcd (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(RCD_LD), .is_zero(rcd_z));
    scg_down_ctr #(.W(CW)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(do_pre), .load_val(RP_LD), .is_zero(rp_z));
    scg_down_ctr #(.W(CW)) u_ras (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(RAS_LD), .is_zero(ras_z));
    scg_down_ctr #(.W(CW)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(RC_LD), .is_zero(rc_z));
    scg_down_ctr #(.W(CW)) u_wrpre (
        .clk(clk), .rst_n(rst_n), .load(do_wr), .load_val(WRPRE_LD), .is_zero(wrpre_z));
    scg_down_ctr #(.W(MW)) u_rmax (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(RMAX_LD), .is_zero(rmax_z));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BANK_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: IDLE --ACTIVE--> OPEN, OPEN --PRECHARGE--> IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            BANK_IDLE: if (do_act) state_nx = BANK_OPEN;
            BANK_OPEN: if (do_pre) state_nx = BANK_IDLE;
            default:   state_nx = BANK_IDLE;
        endcase
    end

    // Readiness per state
    always_comb begin
        act_ready    = 1'b0;
        col_ready    = 1'b0;
        pre_ready    = 1'b0;
        settled_idle = 1'b0;
        must_pre     = 1'b0;
        unique case (state)
            BANK_IDLE: begin
                act_ready    = rp_z && rc_z;
                pre_ready    = 1'b1;
                settled_idle = rp_z;
            end
            BANK_OPEN: begin
                col_ready = rcd_z;
                pre_ready = ras_z && wrpre_z;
                must_pre  = rmax_z;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scg_device_track.sv
module scg_device_track
    import scg_pkg::*;
#(
    parameter int CW      = 5,
    parameter int BL      = 2,
    parameter int RRD_C   = 3,
    parameter int RFC_C   = 13,
    parameter int WRRD_C  = 2,
    parameter int WRBST_C = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue,
    input  logic [2:0] cmd,
    input  logic       cas_lat_3,
    output logic       act_ok,
    output logic       rd_ok,
    output logic       wr_ok,
    output logic       bst_ok,
    output logic       ref_ok
);

    localparam logic [CW-1:0] RRD_LD   = CW'(RRD_C - 1);
    localparam logic [CW-1:0] RFC_LD   = CW'(RFC_C - 1);
    localparam logic [CW-1:0] WRRD_LD  = CW'(WRRD_C - 1);
    localparam logic [CW-1:0] WRBST_LD = CW'(WRBST_C - 1);
    localparam logic [CW-1:0] RDWR3_LD = CW'(3 + BL - 1);
    localparam logic [CW-1:0] RDWR2_LD = CW'(2 + BL - 1);

    dev_state_e state, state_nx;

    logic do_act, do_ref, do_wr, do_rd;
    logic rrd_z, rfc_z, wrrd_z, rdwr_z, wrbst_z;
    logic [CW-1:0] rdwr_ld;

    assign do_act  = issue && (cmd == CMD_ACT);
    assign do_ref  = issue && (cmd == CMD_REF);
    assign do_wr   = issue && (cmd == CMD_WR);
    assign do_rd   = issue && (cmd == CMD_RD);
    assign rdwr_ld = cas_lat_3 ? RDWR3_LD : RDWR2_LD;

    scg_down_ctr #(.W(CW)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(RRD_LD), .is_zero(rrd_z));
    scg_down_ctr #(.W(CW)) u_rfc (
        .clk(clk), .rst_n(rst_n), .load(do_ref), .load_val(RFC_LD), .is_zero(rfc_z));
    scg_down_ctr #(.W(CW)) u_wrrd (
        .clk(clk), .rst_n(rst_n), .load(do_wr), .load_val(WRRD_LD), .is_zero(wrrd_z));
    scg_down_ctr #(.W(CW)) u_rdwr (
        .clk(clk), .rst_n(rst_n), .load(do_rd), .load_val(rdwr_ld), .is_zero(rdwr_z));
    scg_down_ctr #(.W(CW)) u_wrbst (
        .clk(clk), .rst_n(rst_n), .load(do_wr), .load_val(WRBST_LD), .is_zero(wrbst_z));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DEV_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: RUN --REFRESH--> REFRESH, REFRESH --window done--> RUN
    always_comb begin
        state_nx = state;
        unique case (state)
            DEV_RUN:     if (do_ref) state_nx = DEV_REFRESH;
            DEV_REFRESH: if (!do_ref && rfc_z) state_nx = DEV_RUN;
            default:     state_nx = DEV_RUN;
        endcase
    end

    always_comb begin
        act_ok = 1'b0;
        ref_ok = 1'b0;
        unique case (state)
            DEV_RUN: begin
                act_ok = rrd_z;
                ref_ok = 1'b1;
            end
            DEV_REFRESH: begin
                act_ok = rfc_z && rrd_z;
                ref_ok = rfc_z;
            end
            default: ;
        endcase
        rd_ok  = wrrd_z;
        wr_ok  = rdwr_z;
        bst_ok = wrbst_z;
    end

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import scg_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int BANK_W       = $clog2(NUM_BANKS),
    parameter int BURST_LEN    = 2,
    parameter int T_CK_PS      = 5000,
    parameter int T_RRD_PS     = 12000,
    parameter int T_RCD_PS     = 18000,
    parameter int T_RP_PS      = 18000,
    parameter int T_RAS_PS     = 42000,
    parameter int T_RC_PS      = 60000,
    parameter int T_RFC_PS     = 63000,
    parameter int T_RAS_MAX_PS = 100_000_000,
    parameter int CDL_CLK      = 1,
    parameter int RDL_CLK      = 2,
    parameter int BDL_CLK      = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           req_cmd,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic                 req_issue,
    input  logic                 cas_lat_3,
    output logic [7:0]           cmd_ok,
    output logic [NUM_BANKS-1:0] must_pre
);

    localparam int RRD_C    = ps_to_cyc(T_RRD_PS, T_CK_PS);
    localparam int RCD_C    = ps_to_cyc(T_RCD_PS, T_CK_PS);
    localparam int RP_C     = ps_to_cyc(T_RP_PS, T_CK_PS);
    localparam int RAS_C    = ps_to_cyc(T_RAS_PS, T_CK_PS);
    localparam int RC_C     = ps_to_cyc(T_RC_PS, T_CK_PS);
    localparam int RFC_C    = ps_to_cyc(T_RFC_PS, T_CK_PS);
    localparam int RASMAX_C = ps_to_cyc(T_RAS_MAX_PS, T_CK_PS);
    localparam int WRRD_C   = BURST_LEN - 1 + CDL_CLK;
    localparam int WRPRE_C  = BURST_LEN - 1 + RDL_CLK;
    localparam int WRBST_C  = BURST_LEN - 1 + BDL_CLK;
    localparam int RDWR_C   = 3 + BURST_LEN;
    localparam int SHORT_MAX = imax(imax(imax(RRD_C, RCD_C), imax(RP_C, RAS_C)),
                                    imax(imax(RC_C, RFC_C),
                                         imax(imax(WRRD_C, WRPRE_C), imax(WRBST_C, RDWR_C))));
    localparam int CW = $clog2(SHORT_MAX + 1);
    localparam int MW = $clog2(RASMAX_C + 1);

    logic [NUM_BANKS-1:0] b_act, b_col, b_pre, b_settled;
    logic dev_act, dev_rd, dev_wr, dev_bst, dev_ref;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = req_issue && (req_bank == BANK_W'(g));
        scg_bank_track #(
            .CW(CW), .MW(MW),
            .RCD_C(RCD_C), .RP_C(RP_C), .RAS_C(RAS_C), .RC_C(RC_C),
            .WRPRE_C(WRPRE_C), .RASMAX_C(RASMAX_C)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .hit(hit), .cmd(req_cmd),
            .act_ready(b_act[g]), .col_ready(b_col[g]), .pre_ready(b_pre[g]),
            .settled_idle(b_settled[g]), .must_pre(must_pre[g])
        );
    end

    scg_device_track #(
        .CW(CW), .BL(BURST_LEN), .RRD_C(RRD_C), .RFC_C(RFC_C),
        .WRRD_C(WRRD_C), .WRBST_C(WRBST_C)
    ) u_dev (
        .clk(clk), .rst_n(rst_n), .issue(req_issue), .cmd(req_cmd),
        .cas_lat_3(cas_lat_3),
        .act_ok(dev_act), .rd_ok(dev_rd), .wr_ok(dev_wr),
        .bst_ok(dev_bst), .ref_ok(dev_ref)
    );

    // Output process: per-command verdict for the proposed bank
    always_comb begin
        cmd_ok          = '0;
        cmd_ok[CMD_NOP] = 1'b1;
        cmd_ok[CMD_ACT] = b_act[req_bank] && dev_act;
        cmd_ok[CMD_RD]  = b_col[req_bank] && dev_rd;
        cmd_ok[CMD_WR]  = b_col[req_bank] && dev_wr;
        cmd_ok[CMD_PRE] = b_pre[req_bank];
        cmd_ok[CMD_BST] = dev_bst;
        cmd_ok[CMD_REF] = (&b_settled) && dev_ref;
        cmd_ok[CMD_RSV] = 1'b0;
    end

endmodule

// File: rtl/scg_guard_checks.sv
module scg_guard_checks
    import scg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int RRD_C     = 3,
    parameter int RFC_C     = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           req_cmd,
    input logic [BANK_W-1:0]    req_bank,
    input logic                 req_issue,
    input logic [7:0]           cmd_ok,
    input logic [NUM_BANKS-1:0] must_pre
);

    // Input assumption: only allowed commands are issued (R10)
    p_issue_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_issue |-> cmd_ok[req_cmd]);

    p_code_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok[CMD_NOP] && !cmd_ok[CMD_RSV]);

    // A bank cannot be both ready to open and ready for column access (R3)
    p_open_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok[CMD_ACT] && (cmd_ok[CMD_RD] || cmd_ok[CMD_WR])));

    p_act_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (RRD_C > 1) && req_issue && (req_cmd == CMD_ACT) |=> !cmd_ok[CMD_ACT]);

    p_ref_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (RFC_C > 1) && req_issue && (req_cmd == CMD_REF)
        |=> !cmd_ok[CMD_ACT] && !cmd_ok[CMD_REF]);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mp
        p_mustpre_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            must_pre[b] && !(req_issue && (req_cmd == CMD_PRE) && (req_bank == BANK_W'(b)))
            |=> must_pre[b]);
        p_mustpre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            req_issue && (req_cmd == CMD_PRE) && (req_bank == BANK_W'(b))
            |=> !must_pre[b]);
    end

endmodule

bind sdram_cmd_guard scg_guard_checks #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .RRD_C(RRD_C), .RFC_C(RFC_C)
) u_chk (.*);

// File: tb/sdram_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb;

    localparam int TCK    = 5000;
    localparam int BL     = 2;
    localparam int P_RRD  = 12000;
    localparam int P_RCD  = 18000;
    localparam int P_RP   = 18000;
    localparam int P_RAS  = 42000;
    localparam int P_RC   = 80000;
    localparam int P_RFC  = 63000;
    localparam int P_RMAX = 200000;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_PRE = 3'd4, C_BST = 3'd5, C_REF = 3'd6, C_RSV = 3'd7;

    function automatic int cyc(input int ps);
        int c;
        c = (ps + TCK - 1) / TCK;
        return (c < 1) ? 1 : c;
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic       req_issue = 1'b0;
    logic       cas_lat_3 = 1'b1;
    logic [7:0] cmd_ok;
    logic [3:0] must_pre;

    always #2.5 clk = ~clk;

    sdram_cmd_guard #(
        .NUM_BANKS(4), .BURST_LEN(BL), .T_CK_PS(TCK),
        .T_RRD_PS(P_RRD), .T_RCD_PS(P_RCD), .T_RP_PS(P_RP), .T_RAS_PS(P_RAS),
        .T_RC_PS(P_RC), .T_RFC_PS(P_RFC), .T_RAS_MAX_PS(P_RMAX)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_issue(req_issue), .cas_lat_3(cas_lat_3),
        .cmd_ok(cmd_ok), .must_pre(must_pre)
    );

    typedef struct {
        logic [2:0] cmd;
        logic       exp;
        logic       mp_chk;
        logic [3:0] mp_exp;
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Monitor: compares one expected item per cycle, away from the edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (cmd_ok[it.cmd] !== it.exp) begin
                errors++;
                $display("FAIL %s: cmd %0d ok=%b expected %b", it.tag, it.cmd,
                         cmd_ok[it.cmd], it.exp);
            end
            if (it.mp_chk) begin
                checks++;
                if (must_pre !== it.mp_exp) begin
                    errors++;
                    $display("FAIL %s: must_pre=%b expected %b", it.tag, must_pre, it.mp_exp);
                end
            end
        end
    end

    // Driver: present one command per cycle and push its expectation
    task automatic step(input logic [2:0] c, input int b, input logic iss,
                        input logic ex, input string tag,
                        input logic mpc = 1'b0, input logic [3:0] mpe = 4'd0);
        item_t it;
        @(posedge clk);
        #1;
        req_cmd   = c;
        req_bank  = 2'(b);
        req_issue = iss;
        it.cmd = c; it.exp = ex; it.mp_chk = mpc; it.mp_exp = mpe; it.tag = tag;
        q.push_back(it);
    endtask

    // nblk blocked probes, then one allowed cycle (optionally issued)
    task automatic wait_probe(input logic [2:0] c, input int b, input int nblk,
                              input logic iss_end, input string tag);
        for (int i = 0; i < nblk; i++) step(c, b, 1'b0, 1'b0, tag);
        step(c, b, iss_end, 1'b1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state, R10 encoding
        step(C_ACT, 0, 0, 1, "R11 act after reset", 1'b1, 4'b0000);
        step(C_REF, 0, 0, 1, "R11 ref after reset");
        step(C_RSV, 0, 0, 0, "R10 reserved code");
        step(C_NOP, 0, 0, 1, "R10 nop");
        step(C_RD,  0, 0, 0, "R3 read idle bank");

        // R2 activate-to-activate spacing, R1 rounding (12ns/5ns -> 3)
        step(C_ACT, 0, 1, 1, "R2 act b0");
        wait_probe(C_ACT, 1, cyc(P_RRD) - 1, 1, "R2 rrd act b1");

        // R3 activate-to-column (R1: 18ns/5ns -> 4)
        wait_probe(C_RD, 1, cyc(P_RCD) - 1, 1, "R3 rcd read b1");
        // R7 write after read with CL3
        wait_probe(C_WR, 1, 3 + BL - 1, 1, "R7 rd->wr cl3");
        // R5 read after write
        wait_probe(C_RD, 0, BL - 1, 0, "R5 wr->rd");
        // R5 back-to-back writes
        step(C_WR, 0, 1, 1, "R5 wr back-to-back a");
        step(C_WR, 0, 1, 1, "R5 wr back-to-back b");
        // R6 burst stop after write
        wait_probe(C_BST, 0, BL - 1, 0, "R6 wr->bst");
        // R4 write recovery before precharge
        step(C_WR, 0, 1, 1, "R4 wr b0");
        wait_probe(C_PRE, 0, BL - 1 + 2 - 1, 1, "R4 wr->pre");
        // R2 precharge time before activate
        wait_probe(C_ACT, 0, cyc(P_RP) - 1, 1, "R2 rp act b0");
        // R4 minimum row active
        wait_probe(C_PRE, 0, cyc(P_RAS) - 1, 1, "R4 ras pre b0");
        // R2 row cycle dominates here
        wait_probe(C_ACT, 0,
                   ((cyc(P_RP) > cyc(P_RC) - cyc(P_RAS)) ? cyc(P_RP)
                                                          : cyc(P_RC) - cyc(P_RAS)) - 1,
                   0, "R2 rc act b0");

        // R4 precharge to idle bank: allowed, no effect
        step(C_PRE, 2, 1, 1, "R4 pre idle b2");
        step(C_ACT, 2, 0, 1, "R4 pre idle no effect");
        step(C_WR,  2, 0, 0, "R3 write idle bank");

        // R8 refresh
        step(C_REF, 0, 0, 0, "R8 ref with open bank");
        step(C_PRE, 1, 1, 1, "R8 pre b1");
        wait_probe(C_REF, 0, cyc(P_RP) - 1, 1, "R8 ref after rp");
        step(C_REF, 0, 0, 0, "R8 ref back-to-back");
        wait_probe(C_ACT, 3, cyc(P_RFC) - 2, 1, "R8 rfc act b3");

        // R9 maximum row active time
        for (int i = 1; i < cyc(P_RMAX); i++)
            step(C_NOP, 0, 0, 1, "R9 must_pre low", 1'b1, 4'b0000);
        step(C_NOP, 0, 0, 1, "R9 must_pre rise", 1'b1, 4'b1000);
        step(C_PRE, 3, 1, 1, "R9 pre b3", 1'b1, 4'b1000);
        step(C_NOP, 0, 0, 1, "R9 must_pre clear", 1'b1, 4'b0000);

        // R7 with CL2, R5 back-to-back reads
        cas_lat_3 = 1'b0;
        step(C_ACT, 0, 1, 1, "R2 act b0 cl2");
        wait_probe(C_RD, 0, cyc(P_RCD) - 1, 1, "R3 rcd read b0");
        step(C_RD, 0, 1, 1, "R5 rd back-to-back");
        wait_probe(C_WR, 0, 2 + BL - 1, 0, "R7 rd->wr cl2");
        step(C_NOP, 0, 0, 1, "R10 idle");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule